// File: doc/BRIEF.md
# Block-Copy DMA Sequencer

This block moves a run of bytes from one memory region to another without any help from the host processor. Each byte is moved in two halves. In the read half the block puts the source address on the bus, pulses a memory read strobe and keeps the returned byte in an internal holding register. In the write half it puts the destination address on the bus and pulses a memory write strobe while driving the held byte. The source and destination addresses each have their own counter. A single transfer count is shared by both.

Software loads the source address, destination address, count, step direction and fill option on the configuration inputs, then pulses `start`. The block raises a bus hold request and waits until the hold is granted. It then copies bytes until the count runs out or an external stop input is seen. A slow memory can stretch either half with the ready input. With the fill option set, the source address stays fixed, so one byte is written across the whole destination range. When the last write half completes, the block pulses `done` for one clock and drops the hold request.

Top module: `blkcopy_dma`

## Requirements
- R1: A `start` pulse in idle latches the configuration and raises `hreq` and `busy` on the next clock. The block then holds in a request state, with no read or write strobe, for as long as `hack` is low.
- R2: With `rdy` high, each byte takes exactly eight clocks. There are four read-half clocks, with `mem_rd` high in the second and third, followed by four write-half clocks, with `mem_wr` high in the second and third. During `mem_wr`, `wdata` equals the byte sampled on `rdata` at the end of the third read-half clock.
- R3: `mem_rd` and `mem_wr` are never high together. During the read half `mem_addr` is the source address, and during the write half it is the destination address.
- R4: After each byte the destination address moves by +1 when `cfg_dec` is 0 and by -1 when it is 1. The source address moves the same way unless `cfg_fill` is 1, in which case it stays fixed.
- R5: While `rdy` is low, the third clock of either half repeats as a wait state, with the active strobe and the address held.
- R6: A count value of N moves exactly N+1 bytes. The run ends when the count underflows.
- R7: If `eop` is high in any read-half or write-half clock, the run ends after the write half of the byte in progress.
- R8: `done` is high for exactly one clock, in the clock after the final write half. In that same clock `hreq` and `busy` are low.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.
- R10: While reset is held, `hreq`, `busy`, `mem_rd`, `mem_wr` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (acted on in idle only) |
| cfg_src | input | AW | First source address |
| cfg_dst | input | AW | First destination address |
| cfg_cnt | input | CW | Byte count minus one |
| cfg_dec | input | 1 | 1 = addresses step downward |
| cfg_fill | input | 1 | 1 = source address held fixed |
| hreq | output | 1 | Bus hold request |
| hack | input | 1 | Bus hold grant |
| rdy | input | 1 | Memory ready; low inserts wait states |
| eop | input | 1 | External stop request |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| rdata | input | DW | Read data from memory |
| wdata | output | DW | Write data to memory |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
The bench counts the exact number of hold-request clocks in each run. A design with a missing state, an extra state, or an off-by-one count would finish early or late, and it would also leave the byte just past the destination range wrong or untouched when it should not. Wait states are forced in both halves, so a design that ignored `rdy` in the write half, or that sampled read data before the last wait clock, would either miss the expected clock count or store the wrong byte. Downward, fill and early-stop runs check the step direction, the fixed source, and the rule that a stop request finishes the current byte rather than cutting it short. A second `start` during a stalled hold request checks that the latched configuration cannot be overwritten.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_REQ  = 4'd1,
    ST_RD1  = 4'd2,
    ST_RD2  = 4'd3,
    ST_RD3  = 4'd4,
    ST_RD4  = 4'd5,
    ST_WR1  = 4'd6,
    ST_WR2  = 4'd7,
    ST_WR3  = 4'd8,
    ST_WR4  = 4'd9
  } xfer_state_e;

  function automatic logic is_rd_half(xfer_state_e s);
    return (s == ST_RD1) || (s == ST_RD2) || (s == ST_RD3) || (s == ST_RD4);
  endfunction

  function automatic logic is_wr_half(xfer_state_e s);
    return (s == ST_WR1) || (s == ST_WR2) || (s == ST_WR3) || (s == ST_WR4);
  endfunction

endpackage

// File: rtl/blkcopy_addr_ctr.sv
module blkcopy_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          down,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load) begin
      addr_d = load_val;
    end else if (step) begin
      addr_d = down ? (addr - ONE) : (addr + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load || step) begin
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/blkcopy_wcount.sv
module blkcopy_wcount #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
  import blkcopy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        hack,
  input  logic        rdy,
  input  logic        eop,
  input  logic        last,
  output xfer_state_e state,
  output logic        load,
  output logic        capture,
  output logic        step,
  output logic        done
);

  xfer_state_e state_d;
  logic        eop_seen;
  logic        eop_seen_d;
  logic        finish;
  logic        active;
  logic        done_d;

  assign active  = is_rd_half(state) || is_wr_half(state);
  assign load    = (state == ST_IDLE) && start;
  assign capture = (state == ST_RD3) && rdy;
  assign step    = (state == ST_WR4);
  assign finish  = last || eop_seen || eop;
  assign done_d  = step && finish;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (start) state_d = ST_REQ;
      ST_REQ:  if (hack)  state_d = ST_RD1;
      ST_RD1:  state_d = ST_RD2;
      ST_RD2:  state_d = ST_RD3;
      ST_RD3:  if (rdy)   state_d = ST_RD4;
      ST_RD4:  state_d = ST_WR1;
      ST_WR1:  state_d = ST_WR2;
      ST_WR2:  state_d = ST_WR3;
      ST_WR3:  if (rdy)   state_d = ST_WR4;
      ST_WR4:  state_d = finish ? ST_IDLE : ST_RD1;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    eop_seen_d = eop_seen;
    if (load) begin
      eop_seen_d = 1'b0;
    end else if (active && eop) begin
      eop_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      eop_seen <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= state_d;
      eop_seen <= eop_seen_d;
      done     <= done_d;
    end
  end

endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          cfg_dec,
  input  logic          cfg_fill,
  output logic          hreq,
  input  logic          hack,
  input  logic          rdy,
  input  logic          eop,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done
);

  localparam int NPTR   = 2;
  localparam int P_SRC  = 0;
  localparam int P_DST  = 1;

  xfer_state_e   state;
  logic          load;
  logic          capture;
  logic          step;
  logic          last;
  logic          dec_q;
  logic          fill_q;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] ptr      [NPTR];
  logic [AW-1:0] ptr_init [NPTR];
  logic          ptr_step [NPTR];
  logic          rd_half;
  logic          wr_half;

  blkcopy_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hack    (hack),
    .rdy     (rdy),
    .eop     (eop),
    .last    (last),
    .state   (state),
    .load    (load),
    .capture (capture),
    .step    (step),
    .done    (done)
  );

  blkcopy_wcount #(.CW(CW)) u_wcount (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cfg_cnt),
    .dec      (step),
    .last     (last)
  );

  assign ptr_init[P_SRC] = cfg_src;
  assign ptr_init[P_DST] = cfg_dst;
  assign ptr_step[P_SRC] = step && !fill_q;
  assign ptr_step[P_DST] = step;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    blkcopy_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (ptr_init[gi]),
      .step     (ptr_step[gi]),
      .down     (dec_q),
      .addr     (ptr[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= 1'b0;
      fill_q <= 1'b0;
    end else if (load) begin
      dec_q  <= cfg_dec;
      fill_q <= cfg_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= rdata;
    end
  end

  assign rd_half  = is_rd_half(state);
  assign wr_half  = is_wr_half(state);
  assign busy     = (state != ST_IDLE);
  assign hreq     = busy;
  assign mem_rd   = (state == ST_RD2) || (state == ST_RD3);
  assign mem_wr   = (state == ST_WR2) || (state == ST_WR3);
  assign wdata    = wr_half ? hold_q : '0;
  assign mem_addr = rd_half ? ptr[P_SRC] : (wr_half ? ptr[P_DST] : '0);

endmodule

// File: rtl/blkcopy_dma_chk.sv
module blkcopy_dma_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hreq,
  input logic          rdy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] wdata,
  input logic          busy,
  input logic          done
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R3
  AST_STROBE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> hreq); // R1
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $stable(wdata)); // R2
  AST_RD_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && !rdy) |=> (mem_rd && $stable(mem_addr))); // R5
  AST_WR_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && !rdy) |=> (mem_wr && $stable(mem_addr))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!hreq && !busy)); // R8

endmodule

bind blkcopy_dma blkcopy_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hreq     (hreq),
  .rdy      (rdy),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .wdata    (wdata),
  .busy     (busy),
  .done     (done)
);

// File: tb/blkcopy_dma_bench.sv
module blkcopy_dma_bench;

  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] cfg_src;
  logic [AW-1:0] cfg_dst;
  logic [CW-1:0] cfg_cnt;
  logic          cfg_dec;
  logic          cfg_fill;
  logic          hreq;
  logic          hack;
  logic          rdy;
  logic          eop;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic          mem_wr;
  logic [DW-1:0] rdata;
  logic [DW-1:0] wdata;
  logic          busy;
  logic          done;

  logic [7:0] mem [256];
  logic       init_req;
  int         n_chk;
  int         n_fail;

  blkcopy_dma #(.AW(AW), .CW(CW), .DW(DW)) u_blkcopy_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_src  (cfg_src),
    .cfg_dst  (cfg_dst),
    .cfg_cnt  (cfg_cnt),
    .cfg_dec  (cfg_dec),
    .cfg_fill (cfg_fill),
    .hreq     (hreq),
    .hack     (hack),
    .rdy      (rdy),
    .eop      (eop),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .rdata    (rdata),
    .wdata    (wdata),
    .busy     (busy),
    .done     (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (mem_wr && rdy) begin
      mem[mem_addr[7:0]] <= wdata;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fresh_mem();
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
  endtask

  // Runs one transfer. Index n counts negedges after the start edge.
  // rdy is low for n in [lo_a,hi_a) or [lo_b,hi_b); eop is high at n == eop_at.
  task automatic run(input int src, input int dst, input int cnt, input logic dn,
                     input logic fl, input int lo_a, input int hi_a, input int lo_b,
                     input int hi_b, input int eop_at, output int cyc);
    cyc = 0;
    @(negedge clk);
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_cnt = CW'(cnt);
    cfg_dec = dn; cfg_fill = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n < 2000; n++) begin
      if (done) break;
      if (hreq) cyc++;
      rdy = !((n >= lo_a && n < hi_a) || (n >= lo_b && n < hi_b));
      eop = (n == eop_at);
      @(negedge clk);
    end
    rdy = 1'b1; eop = 1'b0;
    chk(done && !hreq && !busy, "R8 done with hold released", int'({done, hreq, busy}), 4);
    @(negedge clk);
    chk(!done, "R8 done lasts one clock", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(!hreq && !busy && !mem_rd && !mem_wr && !done, "R10 reset outputs",
        int'({hreq, busy, mem_rd, mem_wr, done}), 0);
  endtask

  task automatic t_copy_up();
    int cyc;
    fresh_mem();
    run(16'h10, 16'h80, 3, 1'b0, 1'b0, 0, 0, 0, 0, 0, cyc);
    chk(cyc == 33, "R2 eight clocks per byte", cyc, 33);
    for (int i = 0; i < 4; i++)
      chk(mem[8'h80 + i] == pat(16'h10 + i), "R4 upward copy data", int'(mem[8'h80 + i]), int'(pat(16'h10 + i)));
    chk(mem[8'h84] == pat(8'h84), "R6 count N moves N+1 bytes", int'(mem[8'h84]), int'(pat(8'h84)));
  endtask

  task automatic t_copy_down();
    int cyc;
    fresh_mem();
    run(16'h30, 16'hA0, 3, 1'b1, 1'b0, 0, 0, 0, 0, 0, cyc);
    chk(cyc == 33, "R6 downward clock count", cyc, 33);
    for (int i = 0; i < 4; i++)
      chk(mem[8'hA0 - i] == pat(16'h30 - i), "R4 downward copy data", int'(mem[8'hA0 - i]), int'(pat(16'h30 - i)));
    chk(mem[8'h9C] == pat(8'h9C), "R6 byte below range untouched", int'(mem[8'h9C]), int'(pat(8'h9C)));
  endtask

  task automatic t_fill();
    int cyc;
    fresh_mem();
    run(16'h40, 16'hC0, 4, 1'b0, 1'b1, 0, 0, 0, 0, 0, cyc);
    chk(cyc == 41, "R6 fill clock count", cyc, 41);
    for (int i = 0; i < 5; i++)
      chk(mem[8'hC0 + i] == pat(16'h40), "R4 fill keeps source fixed", int'(mem[8'hC0 + i]), int'(pat(16'h40)));
    chk(mem[8'hC5] == pat(8'hC5), "R6 fill range end", int'(mem[8'hC5]), int'(pat(8'hC5)));
  endtask

  task automatic t_wait_states();
    int cyc;
    fresh_mem();
    // two waits in read-half third clock of byte 1, one in its write-half third clock
    run(16'h20, 16'h60, 1, 1'b0, 1'b0, 3, 6, 9, 11, 0, cyc);
    chk(cyc == 20, "R5 wait states add clocks", cyc, 20);
    chk(mem[8'h60] == pat(8'h20), "R5 data after waits", int'(mem[8'h60]), int'(pat(8'h20)));
    chk(mem[8'h61] == pat(8'h21), "R2 second byte after waits", int'(mem[8'h61]), int'(pat(8'h21)));
  endtask

  task automatic t_eop();
    int cyc;
    fresh_mem();
    run(16'h50, 16'hE0, 7, 1'b0, 1'b0, 0, 0, 0, 0, 12, cyc);
    chk(cyc == 17, "R7 stop ends after current byte", cyc, 17);
    chk(mem[8'hE1] == pat(8'h51), "R7 current byte completed", int'(mem[8'hE1]), int'(pat(8'h51)));
    chk(mem[8'hE2] == pat(8'hE2), "R7 no byte after stop", int'(mem[8'hE2]), int'(pat(8'hE2)));
  endtask

  task automatic t_hold_and_restart();
    int cyc;
    logic strobe_seen;
    fresh_mem();
    hack = 1'b0;
    @(negedge clk);
    cfg_src = 16'h08; cfg_dst = 16'h90; cfg_cnt = 1; cfg_dec = 1'b0; cfg_fill = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(hreq && busy, "R1 hold request raised", int'({hreq, busy}), 3);
    strobe_seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (mem_rd || mem_wr) strobe_seen = 1'b1;
      if (k == 2) begin
        cfg_src = 16'h70; cfg_dst = 16'h30; cfg_cnt = 5; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(!strobe_seen && hreq, "R1 no strobe before grant", int'(strobe_seen), 0);
    hack = 1'b1;
    cyc = 0;
    for (int n = 0; n < 200; n++) begin
      if (done) break;
      cyc++;
      @(negedge clk);
    end
    chk(cyc == 17, "R9 restart while busy ignored (length)", cyc, 17);
    chk(mem[8'h90] == pat(8'h08) && mem[8'h91] == pat(8'h09), "R9 original config used",
        int'(mem[8'h91]), int'(pat(8'h09)));
    chk(mem[8'h30] == pat(8'h30), "R9 second config not used", int'(mem[8'h30]), int'(pat(8'h30)));
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; hack = 1'b1; rdy = 1'b1; eop = 1'b0; init_req = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_cnt = '0; cfg_dec = 1'b0; cfg_fill = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_copy_up();
    t_copy_down();
    t_fill();
    t_wait_states();
    t_eop();
    t_hold_and_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule